// File: doc/BRIEF.md
# Hardware Actor Lifecycle Controller

This block keeps the lifecycle state of one hardware thread that lives in a reconfigurable slot. A scheduler sends it four commands (start, suspend, resume, stop). The thread's own logic sends it three events: it is entering a critical transfer, it is making a blocking system call, or its communication has ended. The block shows the current state and a preemptible flag. The scheduler reads that flag before it suspends or relocates the thread.

A thread that is inside a channel transfer is locked. The scheduler cannot suspend or stop it. A suspend sent while the thread is locked is refused at once and is not queued. Any other command that does not fit the current state raises a one-cycle error and leaves the state as it was. The thread leaves the locked state only through its own notification.

Top module: `actor_lifecycle`

## Requirements
- R1: After reset the state is IDLE (code 0), `preemptible` is 1, and both `cmd_error` and `susp_refused` are 0.
- R2: State codes are IDLE=0, RUN=1 (running, preemptible), LOCK=2 (running, non-preemptible), SUSP=3, STOP=4. Command codes on `cmd_op` are start=0, suspend=1, resume=2, stop=3. A start accepted from IDLE or STOP moves the state to RUN on the next clock.
- R3: A suspend in RUN moves the state to SUSP. A resume in SUSP moves it to RUN.
- R4: A stop in any state other than LOCK moves the state to STOP.
- R5: These commands are illegal: start outside IDLE or STOP, resume outside SUSP, suspend in IDLE, SUSP or STOP, and stop in LOCK. An illegal command drives `cmd_error` high for exactly the following cycle. The command itself changes no state.
- R6: A suspend in LOCK drives `susp_refused` high for exactly the following cycle and does not raise `cmd_error`. The state stays LOCK. The request is not kept: after a later unlock, the state is RUN, not SUSP.
- R7: `thr_lock` in RUN moves the state to LOCK.
- R8: `thr_block` or `thr_eoc` in LOCK moves the state to RUN.
- R9: A thread event is ignored in any state where R7 or R8 does not apply.
- R10: When a command is accepted in the same cycle as a thread event, the command decides the next state. When the command is illegal, refused or absent, the event applies.
- R11: `preemptible` is 0 exactly while the state is LOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Scheduler command present this cycle |
| cmd_op | input | 2 | Command code |
| thr_lock | input | 1 | Thread enters a critical channel transfer |
| thr_block | input | 1 | Thread makes a blocking system call |
| thr_eoc | input | 1 | Thread signals end of communication |
| life_state | output | 3 | Current lifecycle state code |
| preemptible | output | 1 | Thread may be suspended or moved |
| cmd_error | output | 1 | One-cycle pulse: previous command was illegal |
| susp_refused | output | 1 | One-cycle pulse: previous suspend was refused because the thread was locked |

## Verification
Seeded random cycles mix all four commands with random thread events, so every state meets every input. A bench model predicts the next state and both pulses for each cycle, and the bench compares them to the outputs.

Directed sequences cover the cases random stimulus may miss or cannot tell apart:
- **Refused versus error:** a suspend sent in LOCK is told apart from an illegal command by which pulse goes high.
- **No queuing:** the unlock after a refused suspend shows that no suspension was stored.
- **Command beats event:** a suspend and a lock event arriving together in RUN show that the command wins.
- **Event applies after a failed command:** an illegal stop together with an end-of-communication event in LOCK shows that the event still takes effect.

// File: rtl/actor_lc_pkg.sv
package actor_lc_pkg;
  localparam int STATE_W = 3;
  localparam int OP_W    = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_LOCK = 3'd2,
    ST_SUSP = 3'd3,
    ST_STOP = 3'd4
  } life_t;

  typedef enum logic [OP_W-1:0] {
    OP_START  = 2'd0,
    OP_SUSP   = 2'd1,
    OP_RESUME = 2'd2,
    OP_STOP   = 2'd3
  } op_t;
endpackage

// File: rtl/actor_cmd_check.sv
module actor_cmd_check
  import actor_lc_pkg::*;
(
  input  life_t cur,
  input  logic  valid,
  input  op_t   op,
  output logic  accept,
  output life_t nxt,
  output logic  illegal,
  output logic  refuse
);
  always_comb begin
    accept  = 1'b0;
    illegal = 1'b0;
    refuse  = 1'b0;
    nxt     = cur;
    if (valid) begin
      unique case (op)
        OP_START: begin
          if (cur == ST_IDLE || cur == ST_STOP) begin
            accept = 1'b1;
            nxt    = ST_RUN;
          end else begin
            illegal = 1'b1;
          end
        end
        OP_SUSP: begin
          if (cur == ST_RUN) begin
            accept = 1'b1;
            nxt    = ST_SUSP;
          end else if (cur == ST_LOCK) begin
            refuse = 1'b1;
          end else begin
            illegal = 1'b1;
          end
        end
        OP_RESUME: begin
          if (cur == ST_SUSP) begin
            accept = 1'b1;
            nxt    = ST_RUN;
          end else begin
            illegal = 1'b1;
          end
        end
        OP_STOP: begin
          if (cur != ST_LOCK) begin
            accept = 1'b1;
            nxt    = ST_STOP;
          end else begin
            illegal = 1'b1;
          end
        end
        default: illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/actor_event_step.sv
module actor_event_step
  import actor_lc_pkg::*;
(
  input  life_t cur,
  input  logic  lock_req,
  input  logic  block_call,
  input  logic  end_comm,
  output logic  change,
  output life_t nxt
);
  always_comb begin
    change = 1'b0;
    nxt    = cur;
    if (cur == ST_RUN && lock_req) begin
      change = 1'b1;
      nxt    = ST_LOCK;
    end else if (cur == ST_LOCK && (block_call || end_comm)) begin
      change = 1'b1;
      nxt    = ST_RUN;
    end
  end
endmodule

// File: rtl/actor_lifecycle.sv
module actor_lifecycle
  import actor_lc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [OP_W-1:0]    cmd_op,
  input  logic               thr_lock,
  input  logic               thr_block,
  input  logic               thr_eoc,
  output logic [STATE_W-1:0] life_state,
  output logic               preemptible,
  output logic               cmd_error,
  output logic               susp_refused
);
  life_t state_q, state_d, cmd_nxt, ev_nxt;
  logic  cmd_acc, cmd_bad, cmd_ref, ev_chg, state_en;
  logic  err_q, ref_q;

  actor_cmd_check u_cmd (
    .cur     (state_q),
    .valid   (cmd_valid),
    .op      (op_t'(cmd_op)),
    .accept  (cmd_acc),
    .nxt     (cmd_nxt),
    .illegal (cmd_bad),
    .refuse  (cmd_ref)
  );

  actor_event_step u_evt (
    .cur        (state_q),
    .lock_req   (thr_lock),
    .block_call (thr_block),
    .end_comm   (thr_eoc),
    .change     (ev_chg),
    .nxt        (ev_nxt)
  );

  // an accepted command outranks a same-cycle thread event
  always_comb begin
    state_en = cmd_acc | ev_chg;
    state_d  = cmd_acc ? cmd_nxt : ev_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      err_q <= cmd_bad;
      ref_q <= cmd_ref;
    end
  end

  assign life_state   = state_q;
  assign preemptible  = (state_q != ST_LOCK);
  assign cmd_error    = err_q;
  assign susp_refused = ref_q;
endmodule

// File: rtl/actor_lifecycle_chk.sv
module actor_lifecycle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       thr_lock,
  input logic       thr_block,
  input logic       thr_eoc,
  input logic [2:0] life_state,
  input logic       preemptible,
  input logic       cmd_error,
  input logic       susp_refused
);
  // R2
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    life_state <= 3'd4);

  // R5
  err_no_cmd_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |-> $past(cmd_valid));

  // R6
  refused_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_refused |-> ($past(life_state) == 3'd2 && $past(cmd_valid) && $past(cmd_op) == 2'd1));

  // R6
  pulses_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_error && susp_refused));

  // R7
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (life_state == 3'd2 && $past(life_state) != 3'd2) |-> ($past(thr_lock) && $past(life_state) == 3'd1));

  // R8
  lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(life_state) == 3'd2 && life_state != 3'd2) |-> (life_state == 3'd1 && ($past(thr_block) || $past(thr_eoc))));

  // R3
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (life_state == 3'd3 && $past(life_state) != 3'd3) |-> $past(life_state) == 3'd1);

  // R11
  preempt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(preemptible) |-> $past(thr_lock));
endmodule

bind actor_lifecycle actor_lifecycle_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .thr_lock     (thr_lock),
  .thr_block    (thr_block),
  .thr_eoc      (thr_eoc),
  .life_state   (life_state),
  .preemptible  (preemptible),
  .cmd_error    (cmd_error),
  .susp_refused (susp_refused)
);

// File: tb/sim_actor_lifecycle.sv
module sim_actor_lifecycle;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic       thr_lock, thr_block, thr_eoc;
  logic [2:0] life_state;
  logic       preemptible, cmd_error, susp_refused;

  int checks = 0;
  int bad = 0;
  int mstate = 0;

  actor_lifecycle u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .thr_lock(thr_lock), .thr_block(thr_block), .thr_eoc(thr_eoc),
    .life_state(life_state), .preemptible(preemptible),
    .cmd_error(cmd_error), .susp_refused(susp_refused)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // model: returns {next_state[4:2], err[1], ref[0]}
  function automatic logic [4:0] model(int s, logic v, logic [1:0] op,
                                       logic lk, logic bl, logic eo);
    int  n = s;
    logic acc = 0, e = 0, r = 0;
    if (v) begin
      case (op)
        2'd0: if (s == 0 || s == 4) begin acc = 1; n = 1; end else e = 1;
        2'd1: if (s == 1) begin acc = 1; n = 3; end else if (s == 2) r = 1; else e = 1;
        2'd2: if (s == 3) begin acc = 1; n = 1; end else e = 1;
        default: if (s != 2) begin acc = 1; n = 4; end else e = 1;
      endcase
    end
    if (!acc) begin
      if (s == 1 && lk) n = 2;
      else if (s == 2 && (bl || eo)) n = 1;
    end
    return {n[2:0], e, r};
  endfunction

  function automatic string tag(int s, logic v, logic [1:0] op, logic [4:0] m);
    if (m[1]) return "R5";
    if (m[0]) return "R6";
    if (v) begin
      if (op == 2'd0) return "R2";
      if (op == 2'd3) return "R4";
      if (m[4:2] != s[2:0] && (s == 1 || s == 2) && op == 2'd1) return "R3";
      if (op == 2'd2) return "R3";
      return "R10";
    end
    if (s == 1 && m[4:2] == 3'd2) return "R7";
    if (s == 2 && m[4:2] == 3'd1) return "R8";
    return "R9";
  endfunction

  task automatic check(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic [1:0] op, logic lk, logic bl, logic eo);
    logic [4:0] m;
    string r;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; thr_lock = lk; thr_block = bl; thr_eoc = eo;
    m = model(mstate, v, op, lk, bl, eo);
    r = tag(mstate, v, op, m);
    @(posedge clk);
    #1;
    check(r, int'(life_state), int'(m[4:2]), "state");
    check(r, int'(cmd_error), int'(m[1]), "cmd_error");
    check(r, int'(susp_refused), int'(m[0]), "susp_refused");
    // R11
    check("R11", int'(preemptible), (m[4:2] != 3'd2) ? 1 : 0, "preemptible");
    mstate = int'(m[4:2]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; thr_lock = 0; thr_block = 0; thr_eoc = 0;
    #(CLK_PERIOD * 3);
    // R1 reset state
    check("R1", int'(life_state), 0, "state");
    check("R1", int'(preemptible), 1, "preemptible");
    check("R1", int'(cmd_error), 0, "cmd_error");
    check("R1", int'(susp_refused), 0, "susp_refused");
    @(negedge clk);
    rst_n = 1'b1;

    // directed: illegal from IDLE (R5), then start (R2)
    step(1, 2'd2, 0, 0, 0);
    step(1, 2'd1, 0, 0, 0);
    step(1, 2'd0, 0, 0, 0);
    step(1, 2'd0, 0, 0, 0);          // R5 start while running
    // R10: suspend and lock together in RUN: suspend wins
    step(1, 2'd1, 1, 0, 0);
    step(0, 2'd0, 0, 0, 1);          // R9 event in SUSP ignored
    step(1, 2'd2, 0, 0, 0);          // R3 resume
    step(0, 2'd0, 1, 0, 0);          // R7 lock
    step(1, 2'd1, 0, 0, 0);          // R6 refused
    step(1, 2'd3, 0, 0, 0);          // R5 stop in LOCK
    step(0, 2'd0, 0, 1, 0);          // R8 unlock by blocking call; R6 not queued
    step(0, 2'd0, 1, 0, 0);
    step(1, 2'd3, 0, 0, 1);          // R10 illegal stop + eoc: event applies
    step(1, 2'd3, 0, 0, 0);          // R4 stop from RUN
    step(0, 2'd0, 1, 1, 1);          // R9 events in STOP ignored
    step(1, 2'd0, 0, 0, 0);          // R2 start from STOP

    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic [3:0] rv;
      rv = 4'($urandom);
      step(rv[1:0] != 2'b00, 2'($urandom), ($urandom % 3) == 0,
           ($urandom % 5) == 0, ($urandom % 5) == 0);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule